// File: doc/BRIEF.md
# Oversampled serial receiver with read-sequenced status flags

This block receives asynchronous serial characters made of one start bit, eight data bits sent least significant bit first, and one stop bit. An external divider supplies a one-cycle enable at sixteen times the bit rate. The block synchronises the receive line and finds the falling edge of a start bit. It then takes three samples in the middle of every bit, uses the majority as the bit value, and writes each finished character into a holding register.

A five-bit status word shows the state of the receiver: a character is waiting, the line has gone idle, a character was lost, a bit was sampled as noisy, or the stop bit was missing. A host reads the status word and the character through two one-cycle read strobes. A flag clears only when the host reads the status word while that flag is set and then reads the character. A wakeup control input blocks idle detection while the receiver is parked.

Top module: `uart_rx_flags`

## Requirements
- R1: After reset `stat_q` is 0 and `data_q` is 0.
- R2: A frame with start 0, eight data bits sent LSB first and stop 1 loads the data byte into `data_q` and sets the full flag, `stat_q[4]`. The load happens when the stop bit is decided.
- R3: Each bit is sampled at oversample ticks 7, 8 and 9, counting from the tick that found the start edge as tick 0. The bit value is the majority of the three samples, so one disagreeing sample does not change the byte.
- R4: The noise flag, `stat_q[1]`, sets with the character when the three samples of any bit in the frame (start, data or stop) are not all equal.
- R5: The framing flag, `stat_q[0]`, sets when the stop bit's majority is 0. The character is still loaded.
- R6: A start bit whose mid-bit majority is 1 sends the receiver back to hunting for a start edge. It sets no flag and leaves `data_q` unchanged.
- R7: If a character completes while the full flag is set and the same cycle does not clear it, the overrun flag, `stat_q[2]`, sets. `data_q` keeps the older character and the new character is discarded.
- R8: The idle flag, `stat_q[3]`, sets after 160 consecutive oversample ticks of a high line, provided the line has been low since the flag was last set. Reset counts as not yet active.
- R9: While `rx_wake` is 1 the idle flag cannot set. An idle condition that is still pending sets the flag once `rx_wake` returns to 0.
- R10: A flag clears on a `data_rd` strobe only if the most recent `stat_rd` strobe saw that flag set. A `data_rd` with no status read before it clears nothing.
- R11: Flag clearing is tracked per flag. A flag that sets after the status read survives the following data read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | One-cycle enable at 16x the bit rate |
| rxd | input | 1 | Serial receive line, idle high |
| rx_wake | input | 1 | Receiver wakeup; 1 blocks idle detection |
| stat_rd | input | 1 | Status read strobe |
| data_rd | input | 1 | Data read strobe |
| stat_q | output | 5 | Flags {full, idle, overrun, noise, framing}, bit 4 down to 0 |
| data_q | output | 8 | Received character |

## Verification
The bench puts a single one-tick glitch on a start bit and on a data bit. A design that used only one sample would return a corrupted byte, and a design that ignored disagreement would leave the noise flag clear. The bench sends a stop bit of 0, a runt start pulse, and two back-to-back frames with no read between them. A faulty design would drop the framing flag, would deliver a phantom character, or would overwrite the unread byte. The bench also interleaves reads with the idle flag setting in between. This catches a design that clears flags on a data read alone, or that clears flags the status read never saw. It also catches one that lets idle set again without line activity, or one that ignores the wakeup input.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
   typedef enum logic [1:0] {
      ST_HUNT  = 2'd0,
      ST_START = 2'd1,
      ST_DATA  = 2'd2,
      ST_STOP  = 2'd3
   } rx_state_e;

   localparam int FLAG_W   = 5;
   localparam int FL_FULL  = 4;
   localparam int FL_IDLE  = 3;
   localparam int FL_OVR   = 2;
   localparam int FL_NOISE = 1;
   localparam int FL_FRAME = 0;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               r <= '1;
            end else begin
               r[0] <= d;
               for (int i = 1; i < STAGES; i++) r[i] <= r[i-1];
            end
         end
         assign q = r[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
   import uart_rx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OSR    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rx,
   output logic              done,
   output logic [DATA_W-1:0] data,
   output logic              noisy,
   output logic              frame_err
);
   localparam int CNT_W = $clog2(OSR);
   localparam int IDX_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] S_A   = CNT_W'(OSR/2 - 1);
   localparam logic [CNT_W-1:0] S_B   = CNT_W'(OSR/2);
   localparam logic [CNT_W-1:0] S_C   = CNT_W'(OSR/2 + 1);
   localparam logic [CNT_W-1:0] C_TOP = CNT_W'(OSR - 1);
   localparam logic [IDX_W-1:0] I_TOP = IDX_W'(DATA_W - 1);

   rx_state_e         state;
   logic [CNT_W-1:0]  cnt;
   logic [IDX_W-1:0]  idx;
   logic [1:0]        smp;
   logic [DATA_W-1:0] shreg;
   logic              noise_acc;
   logic              vote;
   logic              split;

   // Majority of the two stored samples and the live third one.
   always_comb begin
      vote  = (smp[0] & smp[1]) | (smp[0] & rx) | (smp[1] & rx);
      split = !((smp[0] == smp[1]) && (smp[1] == rx));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_HUNT;
         cnt       <= '0;
         idx       <= '0;
         smp       <= '0;
         shreg     <= '0;
         noise_acc <= 1'b0;
         done      <= 1'b0;
         noisy     <= 1'b0;
         frame_err <= 1'b0;
      end else begin
         done <= 1'b0;
         if (tick) begin
            if (state == ST_HUNT) begin
               if (!rx) begin
                  state     <= ST_START;
                  cnt       <= CNT_W'(1);
                  noise_acc <= 1'b0;
               end
            end else begin
               cnt <= (cnt == C_TOP) ? '0 : cnt + 1'b1;
               if (cnt == S_A) smp[0] <= rx;
               if (cnt == S_B) smp[1] <= rx;
               if (cnt == S_C) begin
                  unique case (state)
                     ST_START: begin
                        if (vote) begin
                           state <= ST_HUNT;
                        end else begin
                           noise_acc <= split;
                           idx       <= '0;
                           state     <= ST_DATA;
                        end
                     end
                     ST_DATA: begin
                        shreg     <= {vote, shreg[DATA_W-1:1]};
                        noise_acc <= noise_acc | split;
                        idx       <= idx + 1'b1;
                        if (idx == I_TOP) state <= ST_STOP;
                     end
                     default: begin
                        done      <= 1'b1;
                        noisy     <= noise_acc | split;
                        frame_err <= !vote;
                        state     <= ST_HUNT;
                     end
                  endcase
               end
            end
         end
      end
   end

   assign data = shreg;
endmodule

// File: rtl/uart_rx_idle.sv
module uart_rx_idle #(
   parameter int OSR       = 16,
   parameter int IDLE_BITS = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic rx,
   input  logic inhibit,
   output logic set_o
);
   localparam int LIMIT_I = OSR * IDLE_BITS;
   localparam int W       = $clog2(LIMIT_I + 1);
   localparam logic [W-1:0] LIMIT = W'(LIMIT_I);

   logic [W-1:0] hi_cnt;
   logic         armed;

   assign set_o = armed && (hi_cnt == LIMIT) && !inhibit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt <= '0;
         armed  <= 1'b0;
      end else if (!rx) begin
         hi_cnt <= '0;
         armed  <= 1'b1;
      end else begin
         if (tick && hi_cnt != LIMIT) hi_cnt <= hi_cnt + 1'b1;
         if (set_o) armed <= 1'b0;
      end
   end
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags
   import uart_rx_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int OSR         = 16,
   parameter int IDLE_BITS   = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              os_tick,
   input  logic              rxd,
   input  logic              rx_wake,
   input  logic              stat_rd,
   input  logic              data_rd,
   output logic [FLAG_W-1:0] stat_q,
   output logic [DATA_W-1:0] data_q
);
   generate
      if (OSR < 8) begin : g_bad_osr
         $error("OSR must be at least 8");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must be at least 2");
      end
      if (IDLE_BITS < 1) begin : g_bad_idle
         $error("IDLE_BITS must be at least 1");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 4 or less");
      end
   endgenerate

   logic              rx_s;
   logic              fr_done;
   logic [DATA_W-1:0] fr_data;
   logic              fr_noisy;
   logic              fr_ferr;
   logic              idle_set;
   logic [FLAG_W-1:0] seen_q;
   logic [FLAG_W-1:0] clr_mask;
   logic [FLAG_W-1:0] set_mask;
   logic              accept;

   uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(rxd), .q(rx_s)
   );

   uart_rx_frame #(.DATA_W(DATA_W), .OSR(OSR)) u_frame (
      .clk(clk), .rst_n(rst_n), .tick(os_tick), .rx(rx_s),
      .done(fr_done), .data(fr_data), .noisy(fr_noisy), .frame_err(fr_ferr)
   );

   uart_rx_idle #(.OSR(OSR), .IDLE_BITS(IDLE_BITS)) u_idle (
      .clk(clk), .rst_n(rst_n), .tick(os_tick), .rx(rx_s),
      .inhibit(rx_wake), .set_o(idle_set)
   );

   always_comb begin
      clr_mask = data_rd ? seen_q : '0;
      accept   = fr_done && !(stat_q[FL_FULL] && !clr_mask[FL_FULL]);
      set_mask = '0;
      set_mask[FL_FULL]  = accept;
      set_mask[FL_IDLE]  = idle_set;
      set_mask[FL_OVR]   = fr_done && !accept;
      set_mask[FL_NOISE] = accept && fr_noisy;
      set_mask[FL_FRAME] = accept && fr_ferr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         seen_q <= '0;
         data_q <= '0;
      end else begin
         stat_q <= (stat_q & ~clr_mask) | set_mask;
         if (stat_rd)      seen_q <= stat_q;
         else if (data_rd) seen_q <= '0;
         if (accept) data_q <= fr_data;
      end
   end
endmodule

// File: rtl/uart_rx_flags_chk.sv
module uart_rx_flags_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_wake,
   input logic              data_rd,
   input logic [4:0]        stat_q,
   input logic [DATA_W-1:0] data_q
);
   // R7: overrun only rises while a character is held and stays held
   p_ovr_needs_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_q[2]) |-> ($past(stat_q[4]) && stat_q[4]));

   // R7: the held character is untouched when overrun is raised
   p_ovr_keeps_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_q[2]) |-> $stable(data_q));

   // R2: the data register only moves together with a full flag
   p_load_sets_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(data_q) |-> stat_q[4]);

   // R10: no flag falls without a data read in the cycle before
   p_clear_needs_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (|($past(stat_q) & ~stat_q)) |-> $past(data_rd));

   // R9: idle never rises out of a cycle with wakeup asserted
   p_idle_inhibit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_q[3]) |-> !$past(rx_wake));
endmodule

bind uart_rx_flags uart_rx_flags_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .rx_wake(rx_wake), .data_rd(data_rd),
   .stat_q(stat_q), .data_q(data_q)
);

// File: tb/uart_rx_flags_tb.sv
module uart_rx_flags_tb;
   localparam int TDIV = 4;
   localparam int BITC = 16 * TDIV;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       os_tick = 1'b0;
   logic       rxd = 1'b1;
   logic       rx_wake = 1'b0;
   logic       stat_rd = 1'b0;
   logic       data_rd = 1'b0;
   logic [4:0] stat_q;
   logic [7:0] data_q;
   logic [1:0] div = '0;

   int n_chk = 0;
   int n_fail = 0;
   bit mon_on = 1'b0;

   typedef struct {
      logic [7:0] d;
      logic       nf;
      logic       fe;
      string      req;
   } exp_t;
   exp_t sb[$];

   always #10 clk = ~clk;

   always_ff @(posedge clk) begin
      div     <= div + 2'd1;
      os_tick <= (div == 2'd3);
   end

   uart_rx_flags u_dut (
      .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
      .rx_wake(rx_wake), .stat_rd(stat_rd), .data_rd(data_rd),
      .stat_q(stat_q), .data_q(data_q)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic rd_stat(output logic [4:0] s);
      @(negedge clk);
      s = stat_q;
      stat_rd = 1'b1;
      @(negedge clk);
      stat_rd = 1'b0;
   endtask

   task automatic rd_data(output logic [7:0] d);
      @(negedge clk);
      d = data_q;
      data_rd = 1'b1;
      @(negedge clk);
      data_rd = 1'b0;
   endtask

   task automatic wait_bits(int n);
      repeat (n * BITC) @(negedge clk);
   endtask

   // bit index 0 = start, 1..8 = data, 9 = stop; glitch flips tick 8 only
   task automatic send_frame(logic [7:0] d, int glitch, logic stop_v);
      for (int b = 0; b < 10; b++) begin
         logic v;
         v = (b == 0) ? 1'b0 : (b == 9) ? stop_v : d[b-1];
         for (int t = 0; t < 16; t++) begin
            rxd = (b == glitch && t == 8) ? ~v : v;
            repeat (TDIV) @(negedge clk);
         end
      end
      rxd = 1'b1;
      wait_bits(2);
   endtask

   task automatic push(logic [7:0] d, logic nf, logic fe, string req);
      exp_t e;
      e.d = d; e.nf = nf; e.fe = fe; e.req = req;
      sb.push_back(e);
   endtask

   task automatic monitor();
      forever begin
         @(negedge clk);
         if (mon_on && stat_q[4]) begin
            exp_t e;
            logic [4:0] s;
            logic [7:0] d;
            if (sb.size() == 0) begin
               n_chk++; n_fail++;
               $display("FAIL R2: actual unexpected char %0h expected none", data_q);
            end else begin
               e = sb.pop_front();
               chk({e.req, " data"}, data_q, e.d);
               chk({e.req, " noise"}, stat_q[1], e.nf);
               chk({e.req, " framing"}, stat_q[0], e.fe);
               chk({e.req, " overrun"}, stat_q[2], 0);
            end
            rd_stat(s);
            rd_data(d);
            chk("R10 full cleared", stat_q[4], 0);
         end
      end
   endtask

   initial begin
      logic [4:0] s;
      logic [7:0] d;
      fork
         begin
            repeat (5) @(negedge clk);
            chk("R1 status", stat_q, 0);
            chk("R1 data", data_q, 0);
            rst_n = 1'b1;
            wait_bits(1);
            fork monitor(); join_none
            mon_on = 1'b1;
            // R2 clean frames
            push(8'hA5, 0, 0, "R2"); send_frame(8'hA5, -1, 1'b1);
            push(8'h00, 0, 0, "R2"); send_frame(8'h00, -1, 1'b1);
            push(8'hFF, 0, 0, "R2"); send_frame(8'hFF, -1, 1'b1);
            push(8'h3C, 0, 0, "R2"); send_frame(8'h3C, -1, 1'b1);
            // R3 R4 single odd sample in a data bit and in the start bit
            push(8'h55, 1, 0, "R3 R4"); send_frame(8'h55, 4, 1'b1);
            push(8'hC3, 1, 0, "R4 start"); send_frame(8'hC3, 0, 1'b1);
            // R5 stop bit low
            push(8'h81, 0, 1, "R5"); send_frame(8'h81, -1, 1'b0);
            wait_bits(1);
            mon_on = 1'b0;
            chk("R2 scoreboard drained", sb.size(), 0);
            // R6 runt start
            rxd = 1'b0;
            repeat (3 * TDIV) @(negedge clk);
            rxd = 1'b1;
            wait_bits(2);
            chk("R6 status", stat_q, 0);
            chk("R6 data", data_q, 8'h81);
            // R7 overrun
            send_frame(8'h11, -1, 1'b1);
            send_frame(8'h22, -1, 1'b1);
            chk("R7 status", stat_q, 5'b10100);
            chk("R7 data", data_q, 8'h11);
            rd_stat(s);
            rd_data(d);
            chk("R7 read char", d, 8'h11);
            chk("R10 overrun cleared", stat_q, 0);
            // R10 data read without status read
            send_frame(8'h33, -1, 1'b1);
            rd_data(d);
            chk("R10 no clear", stat_q, 5'b10000);
            rd_stat(s);
            rd_data(d);
            chk("R10 char", d, 8'h33);
            chk("R10 cleared", stat_q, 0);
            // R11 idle sets between status and data read
            send_frame(8'h44, -1, 1'b1);
            rd_stat(s);
            chk("R11 seen", s, 5'b10000);
            wait_bits(11);
            rd_data(d);
            chk("R11 idle survives", stat_q, 5'b01000);
            rd_stat(s);
            rd_data(d);
            chk("R8 idle cleared", stat_q, 0);
            // R8 no re-set without activity
            wait_bits(12);
            chk("R8 no rearm", stat_q, 0);
            send_frame(8'h77, -1, 1'b1);
            rd_stat(s);
            rd_data(d);
            chk("R8 char", d, 8'h77);
            wait_bits(11);
            chk("R8 idle again", stat_q, 5'b01000);
            rd_stat(s);
            rd_data(d);
            // R9 wakeup inhibits idle
            rx_wake = 1'b1;
            send_frame(8'h12, -1, 1'b1);
            rd_stat(s);
            rd_data(d);
            wait_bits(12);
            chk("R9 inhibited", stat_q, 0);
            rx_wake = 1'b0;
            repeat (4) @(negedge clk);
            chk("R9 released", stat_q, 5'b01000);
            rd_stat(s);
            rd_data(d);
            chk("R10 final clear", stat_q, 0);
         end
         begin
            repeat (150000) @(posedge clk);
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule